// File: doc/BRIEF.md
# Packet Page Data Window

This block gives a byte-wide host port into packet buffer pages of 2048 bytes each. The host loads a 16-bit pointer one byte at a time. It then moves bytes through a data window that is four byte addresses wide. The pointer does three jobs. Its top bit picks the page: either the page at the head of the receive queue or the page named by the packet-number input. The bit below it turns offset auto-increment on or off. Its low eleven bits hold the byte offset inside the page.

Each data-window access produces one buffer address, which is the page index followed by the offset. A write drives the write enable together with the host byte. A read drives a read enable to a synchronous buffer, and the byte comes back on the read data output in the next cycle. With auto-increment on, every data access uses the current offset and then steps it by one, so a whole frame can be streamed through any window lane. With auto-increment off, the pointer stays fixed and the window lane is added to the offset, so up to four neighbouring bytes can be reached without reloading the pointer.

Top module: `pkt_window_port`

## Requirements
- R1: After reset the pointer is zero, both buffer strobes are low and the read data output is zero.
- R2: A write at select 0 loads pointer bits 7:0 and a write at select 1 loads pointer bits 15:8. A read at either select returns that byte on the read data output in the cycle after the strobe.
- R3: A read of the pointer high byte (select 1) always returns bit 3 as zero, even when pointer bit 11 is set.
- R4: In the cycle of a data-window access, buffer address bits 12:11 carry the receive-head page index when pointer bit 15 is 1, and the packet-number page when it is 0.
- R5: A data-window access is a strobe at selects 4 to 7. During it, the buffer address bits 10:0 carry the accessed offset in that same cycle. A write raises the write enable and presents the host byte on the buffer write data.
- R6: With pointer bit 14 set, a data access uses offset bits 10:0 unchanged, whatever the lane. It then increments bits 10:0 modulo 2048 and leaves bits 15:11 as they were.
- R7: With pointer bit 14 clear, a data access uses bits 10:0 plus lane select[1:0], modulo 2048, and leaves the pointer unchanged.
- R8: A data-window read raises the buffer read enable. The read data output shows the buffer byte returned in the following cycle.
- R9: Writes at select 2 or 3 change nothing, and reads there return zero.
- R10: When read and write strobes are raised together, only the write takes effect. The read enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| regSel | input | 3 | 0 pointer low, 1 pointer high, 2-3 unused, 4-7 data window lanes 0-3 |
| wrData | input | 8 | Host write byte |
| pktNum | input | 2 | Page index from the packet-number register |
| rxHead | input | 2 | Page index at the receive queue head |
| memRdata | input | 8 | Byte from the synchronous buffer, one cycle after memRe |
| memAddr | output | 13 | Buffer byte address {page, offset} |
| memWe | output | 1 | Buffer write enable |
| memRe | output | 1 | Buffer read enable |
| memWdata | output | 8 | Buffer write byte |
| rdData | output | 8 | Host read byte, valid the cycle after a read |

## Verification
If the pointer offset is wrong, it shows on memAddr at the very next data strobe. If the upper pointer bits are wrong, the page bits of memAddr change, and a pointer read-back exposes the fault two cycles after the access. A wrong increment or lane carry shows as an address that drifts, which the bench catches at the wrap points 2047 to 0. An error in the read path shows on rdData exactly one cycle after the strobe.

// File: rtl/pwp_pkg.sv
`timescale 1ns/1ps
package pwp_pkg;
  typedef struct packed {
    logic       ptrLoWr;
    logic       ptrHiWr;
    logic       dataWr;
    logic       dataRd;
    logic       ptrLoRd;
    logic       ptrHiRd;
    logic       nullRd;
    logic [1:0] lane;
  } pwpCtl_t;
endpackage

// File: rtl/pwp_ctrl.sv
`timescale 1ns/1ps
module pwp_ctrl
  import pwp_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] regSel,
  output pwpCtl_t          ctl
);
  logic isData;
  logic rdAct;

  assign isData = regSel[SEL_W-1];
  assign rdAct  = rdEn & ~wrEn;   // write has priority

  always_comb begin
    ctl         = '0;
    ctl.lane    = regSel[1:0];
    ctl.dataWr  = wrEn  & isData;
    ctl.dataRd  = rdAct & isData;
    ctl.ptrLoWr = wrEn  & ~isData & (regSel[1:0] == 2'd0);
    ctl.ptrHiWr = wrEn  & ~isData & (regSel[1:0] == 2'd1);
    ctl.ptrLoRd = rdAct & ~isData & (regSel[1:0] == 2'd0);
    ctl.ptrHiRd = rdAct & ~isData & (regSel[1:0] == 2'd1);
    ctl.nullRd  = rdAct & ~isData & regSel[1];
  end
endmodule

// File: rtl/pwp_dpath.sv
`timescale 1ns/1ps
module pwp_dpath
  import pwp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 2048,
  parameter int PAGES      = 4,
  localparam int PTR_W     = 2 * DATA_W,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int ADDR_W    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwpCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PAGE_W-1:0] pktNum,
  input  logic [PAGE_W-1:0] rxHead,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptrQ
);
  localparam int RXSEL_BIT = PTR_W - 1;
  localparam int INC_BIT   = PTR_W - 2;
  localparam logic [DATA_W-1:0] HI_MASK = ~(DATA_W'(1) << 3);

  logic              autoInc;
  logic [OFF_W-1:0]  baseOff;
  logic [OFF_W-1:0]  accOff;
  logic [PAGE_W-1:0] page;
  logic              dataAcc;
  logic              rdFromMem;
  logic [DATA_W-1:0] heldByte;

  assign autoInc = ptrQ[INC_BIT];
  assign baseOff = ptrQ[OFF_W-1:0];
  assign accOff  = autoInc ? baseOff : baseOff + OFF_W'(ctl.lane);
  assign page    = ptrQ[RXSEL_BIT] ? rxHead : pktNum;
  assign dataAcc = ctl.dataWr | ctl.dataRd;

  assign memAddr  = {page, accOff};
  assign memWe    = ctl.dataWr;
  assign memRe    = ctl.dataRd;
  assign memWdata = wrData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ <= '0;
    end else if (ctl.ptrLoWr) begin
      ptrQ[DATA_W-1:0] <= wrData;
    end else if (ctl.ptrHiWr) begin
      ptrQ[PTR_W-1:DATA_W] <= wrData;
    end else if (dataAcc && autoInc) begin
      ptrQ[OFF_W-1:0] <= baseOff + OFF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdFromMem <= 1'b0;
      heldByte  <= '0;
    end else if (ctl.dataRd) begin
      rdFromMem <= 1'b1;
    end else if (ctl.ptrLoRd || ctl.ptrHiRd || ctl.nullRd) begin
      rdFromMem <= 1'b0;
      if (ctl.ptrLoRd)      heldByte <= ptrQ[DATA_W-1:0];
      else if (ctl.ptrHiRd) heldByte <= ptrQ[PTR_W-1:DATA_W] & HI_MASK;
      else                  heldByte <= '0;
    end
  end

  assign rdData = rdFromMem ? memRdata : heldByte;
endmodule

// File: rtl/pkt_window_port.sv
`timescale 1ns/1ps
module pkt_window_port
  import pwp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 2048,
  parameter int PAGES      = 4,
  localparam int PTR_W     = 2 * DATA_W,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int ADDR_W    = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PAGE_W-1:0] pktNum,
  input  logic [PAGE_W-1:0] rxHead,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData
);
  pwpCtl_t          ctl;
  logic [PTR_W-1:0] ptrQ;

  pwp_ctrl #(.SEL_W(3)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel), .ctl(ctl)
  );

  pwp_dpath #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(wrData),
    .pktNum(pktNum), .rxHead(rxHead), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .rdData(rdData), .ptrQ(ptrQ)
  );
endmodule

// File: rtl/pwp_checker.sv
`timescale 1ns/1ps
module pwp_checker #(
  parameter int PTR_W  = 16,
  parameter int OFF_W  = 11,
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic              rdEn,
  input logic [2:0]        regSel,
  input logic [PAGE_W-1:0] pktNum,
  input logic [PAGE_W-1:0] rxHead,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              memRe,
  input logic [7:0]        rdData,
  input logic [PTR_W-1:0]  ptrQ
);
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || memRe) && ptrQ[PTR_W-2] |=> ptrQ[OFF_W-1:0] == $past(ptrQ[OFF_W-1:0]) + OFF_W'(1));

  a_r6_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || memRe) |=> ptrQ[PTR_W-1:OFF_W] == $past(ptrQ[PTR_W-1:OFF_W]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || memRe) && !ptrQ[PTR_W-2] |=> $stable(ptrQ));

  a_r4_page: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || memRe) |-> memAddr[ADDR_W-1:OFF_W] == (ptrQ[PTR_W-1] ? rxHead : pktNum));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && rdEn |-> !memRe);

  a_r5_we_source: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> wrEn && regSel[2]);

  a_r3_mask: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn && !wrEn && regSel == 3'd1 |=> !rdData[3]);

  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && regSel[2:1] == 2'b01 |=> $stable(ptrQ));
endmodule

bind pkt_window_port pwp_checker #(
  .PTR_W(PTR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
  .pktNum(pktNum), .rxHead(rxHead), .memAddr(memAddr), .memWe(memWe),
  .memRe(memRe), .rdData(rdData), .ptrQ(ptrQ)
);

// File: tb/tb_pkt_window_port.sv
`timescale 1ns/1ps
module tb_pkt_window_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  pktNum = 2'd2, rxHead = 2'd1;
  logic [7:0]  memRdata = '0;
  logic [12:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata, rdData;

  int nChk = 0, nErr = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pkt_window_port dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .pktNum(pktNum), .rxHead(rxHead), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .rdData(rdData)
  );

  function automatic logic [7:0] memf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // synchronous buffer model with one cycle of read latency
  always @(posedge clk) if (memRe) memRdata <= memf(memAddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit rd, input logic [2:0] sel, input logic [7:0] d,
                        output logic [12:0] a, output logic we, output logic re,
                        output logic [7:0] wd, output logic [7:0] r);
    @(negedge clk);
    wrEn = wr; rdEn = rd; regSel = sel; wrData = d;
    #1;
    a = memAddr; we = memWe; re = memRe; wd = memWdata;
    @(negedge clk);
    r = rdData;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  // {wr, sel[2:0], data[7:0], expAddr[12:0], expRd[7:0], flags[1:0], req[3:0]}
  // flags bit0: check strobes/address, bit1: check read data
  localparam int NV = 21;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'h10, 13'h0000, 8'h00, 2'b00, 4'd2},  // R2 ptr low
    {1'b1, 3'd1, 8'h40, 13'h0000, 8'h00, 2'b00, 4'd2},  // R2 ptr high, inc mode
    {1'b0, 3'd1, 8'h00, 13'h0000, 8'h40, 2'b10, 4'd2},  // R2 read high
    {1'b0, 3'd0, 8'h00, 13'h0000, 8'h10, 2'b10, 4'd2},  // R2 read low
    {1'b1, 3'd4, 8'hAA, 13'h1010, 8'h00, 2'b01, 4'd6},  // R6 inc write lane 0
    {1'b1, 3'd7, 8'hBB, 13'h1011, 8'h00, 2'b01, 4'd6},  // R6 lane ignored
    {1'b0, 3'd5, 8'h00, 13'h1012, 8'h00, 2'b11, 4'd8},  // R8 data read
    {1'b0, 3'd0, 8'h00, 13'h0000, 8'h13, 2'b10, 4'd6},  // R6 offset advanced 3
    {1'b1, 3'd1, 8'h80, 13'h0000, 8'h00, 2'b00, 4'd4},  // R4 rx page, no inc
    {1'b0, 3'd4, 8'h00, 13'h0813, 8'h00, 2'b11, 4'd4},  // R4 rx head page
    {1'b0, 3'd6, 8'h00, 13'h0815, 8'h00, 2'b11, 4'd7},  // R7 lane 2
    {1'b1, 3'd7, 8'h05, 13'h0816, 8'h00, 2'b01, 4'd7},  // R7 lane 3
    {1'b0, 3'd0, 8'h00, 13'h0000, 8'h13, 2'b10, 4'd7},  // R7 pointer unchanged
    {1'b1, 3'd1, 8'h0F, 13'h0000, 8'h00, 2'b00, 4'd2},  // R2 high with bit 11 set
    {1'b0, 3'd1, 8'h00, 13'h0000, 8'h07, 2'b10, 4'd3},  // R3 bit 3 masked
    {1'b0, 3'd4, 8'h00, 13'h1713, 8'h00, 2'b11, 4'd5},  // R5 offset uses bits 10:8
    {1'b1, 3'd2, 8'h99, 13'h0000, 8'h00, 2'b01, 4'd9},  // R9 ignored write
    {1'b0, 3'd2, 8'h00, 13'h0000, 8'h00, 2'b10, 4'd9},  // R9 reads zero
    {1'b0, 3'd3, 8'h00, 13'h0000, 8'h00, 2'b10, 4'd9},  // R9 reads zero
    {1'b0, 3'd0, 8'h00, 13'h0000, 8'h13, 2'b10, 4'd9},  // R9 pointer low intact
    {1'b0, 3'd1, 8'h00, 13'h0000, 8'h07, 2'b10, 4'd9}   // R9 pointer high intact
  };

  initial begin
    logic [12:0] a; logic we, re; logic [7:0] wd, r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, memWe}, 0);
    chk("R1", {31'd0, memRe}, 0);
    chk("R1", {24'd0, rdData}, 0);
    rst_n = 1'b1;
    access(0, 1, 3'd0, 8'h00, a, we, re, wd, r); chk("R1", {24'd0, r}, 0);
    access(0, 1, 3'd1, 8'h00, a, we, re, wd, r); chk("R1", {24'd0, r}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      string req;
      v = VEC[i];
      req = $sformatf("R%0d", v[3:0]);
      access(v[38], !v[38], v[37:35], v[34:27], a, we, re, wd, r);
      if (v[4]) begin
        if (v[37]) begin
          chk(req, {19'd0, a}, {19'd0, v[26:14]});
          chk(req, {30'd0, we, re}, {30'd0, v[38], !v[38]});
          if (v[38]) chk("R5", {24'd0, wd}, {24'd0, v[34:27]});
        end else begin
          chk(req, {30'd0, we, re}, 0);
        end
      end
      if (v[5]) begin
        if (v[37]) chk(req, {24'd0, r}, {24'd0, memf(v[26:14])});
        else       chk(req, {24'd0, r}, {24'd0, v[13:6]});
      end
    end

    // R6 increment wraps 2047 -> 0 and keeps bits 15:11
    access(1, 0, 3'd0, 8'hFF, a, we, re, wd, r);
    access(1, 0, 3'd1, 8'hFF, a, we, re, wd, r);
    access(0, 1, 3'd4, 8'h00, a, we, re, wd, r);
    chk("R6", {19'd0, a}, 32'h0FFF);
    chk("R8", {24'd0, r}, {24'd0, memf(13'h0FFF)});
    access(0, 1, 3'd0, 8'h00, a, we, re, wd, r); chk("R6", {24'd0, r}, 32'h00);
    access(0, 1, 3'd1, 8'h00, a, we, re, wd, r); chk("R6", {24'd0, r}, 32'hF0);

    // R7 lane addition wraps within the page
    access(1, 0, 3'd1, 8'h07, a, we, re, wd, r);
    access(1, 0, 3'd0, 8'hFE, a, we, re, wd, r);
    access(1, 0, 3'd7, 8'h33, a, we, re, wd, r);
    chk("R7", {19'd0, a}, 32'h1001);
    access(0, 1, 3'd0, 8'h00, a, we, re, wd, r); chk("R7", {24'd0, r}, 32'hFE);

    // R10 simultaneous strobes: write wins
    access(1, 1, 3'd4, 8'h5A, a, we, re, wd, r);
    chk("R10", {30'd0, we, re}, 32'h2);
    chk("R10", {19'd0, a}, 32'h17FE);

    // R4 receive head follows its input
    rxHead = 2'd3;
    access(1, 0, 3'd1, 8'h80, a, we, re, wd, r);
    access(0, 1, 3'd4, 8'h00, a, we, re, wd, r);
    chk("R4", {19'd0, a}, 32'h18FE);

    // R1 reset mid-run clears the pointer
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(0, 1, 3'd1, 8'h00, a, we, re, wd, r); chk("R1", {24'd0, r}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end
endmodule